// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects 32 interrupt sources and steers each one to a grid of parent interrupt outputs arranged as four lines by four cores. Every source is first passed through a two-flop synchroniser. It is then qualified as either level-sensitive or edge-sensitive, with a selectable active sense. Edge-sensitive sources latch a pending bit that stays set until software acknowledges it. Software reaches the controller through a simple register bus that takes single-byte and full-word writes and returns word reads.

Enables are never written as a whole mask. One word address sets the enable bits, another clears them, and a bit written as 0 at either address changes nothing. Each source has its own routing byte. The upper nibble of that byte picks parent lines and the lower nibble picks cores. A grid output is high when at least one enabled, asserting source selects both its line and its core.

Top module: `rlic_top`

## Requirements
- R1: After reset the enable, polarity and trigger-type registers read 0, all routing bytes read 0, the status register reads 0 and every grid output is 0.
- R2: A byte write (bus_word=0) to offset N, for N in 0x00..0x1F, stores wdata[7:0] as the routing byte of source N. In that byte, bit c (c=0..3) selects core c and bit 4+l selects line l. A word read at aligned offset 4k returns the bytes of sources 4k..4k+3, with source 4k in bits [7:0].
- R3: A word write to offset 0x28 sets the enable of every source whose data bit is 1.
- R4: A word write to offset 0x2C clears the enable of every source whose data bit is 1. Data bits of 0 at 0x28 or 0x2C leave the enables unchanged.
- R5: A word read at offset 0x24 returns the current enable mask, with bit N belonging to source N.
- R6: A word write to 0x34 sets the trigger types (bit 1 = edge, 0 = level) and a word write to 0x30 sets the polarities (bit 1 = active-high or rising, 0 = active-low or falling). Both registers read back at their own offsets.
- R7: A level source asserts while its synchronised input equals its polarity bit. An input change reaches the status register after the second rising clock edge.
- R8: An edge source sets its pending bit on the selected edge of its synchronised input and keeps it after the input returns. The pending bit is cleared only by a 1 for that source written to 0x2C.
- R9: A word read at 0x40 returns the status: for each source, its enable ANDed with its asserted condition (the pending bit for edge sources, the level condition for level sources).
- R10: Grid output bit l*4+c is registered. It goes high one clock after the status holds an enabled source whose routing byte has both bit 4+l and bit c set, and it is 0 one clock after the status is all zero.
- R11: Writes of the wrong size have no effect: a byte write to 0x28..0x34 and a word write into the routing region 0x00..0x1F change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_word | input | 1 | 1 = word write, 0 = byte write (data in wdata[7:0]) |
| bus_addr | input | 8 | Byte offset for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Word read data for bus_addr, combinational |
| irq_src | input | 32 | Raw asynchronous interrupt sources |
| irq_out | output | 16 | Parent outputs, bit line*4+core |

## Verification
The hardest case to reach from the ports is an edge-sensitive source whose pending bit must survive after its input has gone away, and must survive other enable writes too, until a clear write hits exactly that bit. The stimulus builds this in a directed way: it produces an edge, returns the input to its idle level, and confirms that the status still holds. After that, random sequences mix input toggles with polarity, trigger-type, enable and routing writes. A bench model follows the pending bits from the input transitions that the bench itself drives.

// File: rtl/rlic_pkg.sv
package rlic_pkg;
  localparam int          ROUTE_BYTES = 32;
  localparam logic [7:0]  OFS_EN_RD   = 8'h24;
  localparam logic [7:0]  OFS_EN_SET  = 8'h28;
  localparam logic [7:0]  OFS_EN_CLR  = 8'h2C;
  localparam logic [7:0]  OFS_POL     = 8'h30;
  localparam logic [7:0]  OFS_TRIG    = 8'h34;
  localparam logic [7:0]  OFS_STAT    = 8'h40;

  // level condition: input matches its polarity bit
  function automatic logic level_on(input logic s, input logic pol);
    return ~(s ^ pol);
  endfunction

  // selected edge between previous and current synchronised sample
  function automatic logic edge_on(input logic s, input logic s_prev, input logic pol);
    return pol ? (s & ~s_prev) : (~s & s_prev);
  endfunction

  // routing byte picks line l (upper nibble) and core c (lower nibble)
  function automatic logic route_sel(input logic [7:0] r, input int l, input int c);
    return r[4+l] & r[c];
  endfunction
endpackage

// File: rtl/rlic_regs.sv
module rlic_regs
  import rlic_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_word,
  input  logic [7:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  input  logic [NUM_SRC-1:0]      status,
  output logic [31:0]             bus_rdata,
  output logic [NUM_SRC-1:0]      en_q,
  output logic [NUM_SRC-1:0]      pol_q,
  output logic [NUM_SRC-1:0]      trig_q,
  output logic [NUM_SRC-1:0][7:0] route_q,
  output logic [NUM_SRC-1:0]      clr_mask
);
  logic word_wr, byte_wr;
  logic [NUM_SRC-1:0] wmask;

  assign word_wr  = bus_wr & bus_word;
  assign byte_wr  = bus_wr & ~bus_word;
  assign wmask    = bus_wdata[NUM_SRC-1:0];
  assign clr_mask = (word_wr && bus_addr == OFS_EN_CLR) ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (word_wr) begin
      case (bus_addr)
        OFS_EN_SET: en_q   <= en_q | wmask;
        OFS_EN_CLR: en_q   <= en_q & ~wmask;
        OFS_POL:    pol_q  <= wmask;
        OFS_TRIG:   trig_q <= wmask;
        default:    ;
      endcase
    end
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        route_q[n] <= '0;
      else if (byte_wr && bus_addr == 8'(n))
        route_q[n] <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if ({bus_addr[7:2], 2'b00} < 8'(NUM_SRC)) begin
      for (int b = 0; b < 4; b++) begin
        if (int'({bus_addr[7:2], 2'b00}) + b < NUM_SRC)
          bus_rdata[8*b +: 8] = route_q[int'({bus_addr[7:2], 2'b00}) + b];
      end
    end else begin
      case (bus_addr)
        OFS_EN_RD: bus_rdata[NUM_SRC-1:0] = en_q;
        OFS_POL:   bus_rdata[NUM_SRC-1:0] = pol_q;
        OFS_TRIG:  bus_rdata[NUM_SRC-1:0] = trig_q;
        OFS_STAT:  bus_rdata[NUM_SRC-1:0] = status;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr && bus_addr == OFS_EN_SET) |=> ((en_q & $past(wmask)) == $past(wmask)));

  assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr && bus_addr == OFS_EN_CLR) |=> ((en_q & $past(wmask)) == '0));

  assert_en_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_wr && (bus_addr == OFS_EN_SET || bus_addr == OFS_EN_CLR)) |=> $stable(en_q));

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr |=> ($stable(pol_q) && $stable(trig_q) && $stable(en_q)));
endmodule

// File: rtl/rlic_detect.sv
module rlic_detect
  import rlic_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [NUM_SRC-1:0] pol_q,
  input  logic [NUM_SRC-1:0] trig_q,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] asserted,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] edge_hit
);
  logic [NUM_SRC-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= irq_src;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign edge_hit[i] = edge_on(sync_q[i], prev_q[i], pol_q[i]);
    assign asserted[i] = trig_q[i] ? pend_q[i] : level_on(sync_q[i], pol_q[i]);

    // a fresh edge wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend_q[i] <= 1'b0;
      else if (edge_hit[i])
        pend_q[i] <= 1'b1;
      else if (clr_mask[i])
        pend_q[i] <= 1'b0;
    end
  end

  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_q) & ~$past(clr_mask) & ~pend_q) == '0);

  assert_pend_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (~$past(pend_q) & ~$past(edge_hit) & pend_q) == '0);
endmodule

// File: rtl/rlic_router.sv
module rlic_router
  import rlic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_LINE = 4,
  parameter int NUM_CORE = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           status,
  input  logic [NUM_SRC-1:0][7:0]      route_q,
  output logic [NUM_LINE*NUM_CORE-1:0] irq_out
);
  localparam int OUT_W = NUM_LINE * NUM_CORE;
  logic [OUT_W-1:0] grid_d;

  for (genvar l = 0; l < NUM_LINE; l++) begin : g_line
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      always_comb begin
        grid_d[l*NUM_CORE+c] = 1'b0;
        for (int s = 0; s < NUM_SRC; s++)
          grid_d[l*NUM_CORE+c] |= status[s] & route_sel(route_q[s], l, c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= grid_d;
  end

  assert_out_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> (irq_out == '0));

  assert_out_unrouted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '0) |=> (irq_out == '0));
endmodule

// File: rtl/rlic_top.sv
module rlic_top
  import rlic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_LINE = 4,
  parameter int NUM_CORE = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic                         bus_word,
  input  logic [7:0]                   bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic [NUM_SRC-1:0]           irq_src,
  output logic [NUM_LINE*NUM_CORE-1:0] irq_out
);
  logic [NUM_SRC-1:0]      en_q, pol_q, trig_q, clr_mask;
  logic [NUM_SRC-1:0]      asserted, pend_q, edge_hit, status;
  logic [NUM_SRC-1:0][7:0] route_q;

  assign status = en_q & asserted;

  rlic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status(status),
    .bus_rdata(bus_rdata), .en_q(en_q), .pol_q(pol_q), .trig_q(trig_q),
    .route_q(route_q), .clr_mask(clr_mask)
  );

  rlic_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .pol_q(pol_q),
    .trig_q(trig_q), .clr_mask(clr_mask), .asserted(asserted),
    .pend_q(pend_q), .edge_hit(edge_hit)
  );

  rlic_router #(.NUM_SRC(NUM_SRC), .NUM_LINE(NUM_LINE), .NUM_CORE(NUM_CORE)) u_router (
    .clk(clk), .rst_n(rst_n), .status(status), .route_q(route_q), .irq_out(irq_out)
  );

  assert_stat_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (bus_addr != OFS_STAT || bus_rdata == '0));
endmodule

// File: tb/rlic_top_tb.sv
module rlic_top_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_word = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_src = 0;
  logic [15:0] irq_out;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] m_en = 0, m_pol = 0, m_trig = 0, m_pend = 0, m_src = 0;
  logic [7:0]  m_route [32];

  always #5 clk = ~clk;

  rlic_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return m_en & ((m_trig & m_pend) | (~m_trig & ~(m_src ^ m_pol)));
  endfunction

  function automatic logic [15:0] exp_grid();
    logic [31:0] st = exp_status();
    logic [15:0] g = '0;
    for (int s = 0; s < 32; s++)
      for (int l = 0; l < 4; l++)
        for (int c = 0; c < 4; c++)
          if (st[s] && m_route[s][4+l] && m_route[s][c]) g[l*4+c] = 1'b1;
    return g;
  endfunction

  function automatic logic [31:0] edges(input logic [31:0] from_v, input logic [31:0] to_v);
    return (m_pol & to_v & ~from_v) | (~m_pol & ~to_v & from_v);
  endfunction

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wr(input logic word, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_word = word; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    if (word) begin
      case (a)
        8'h28: m_en = m_en | d;
        8'h2C: begin m_en = m_en & ~d; m_pend = m_pend & ~d; end
        8'h30: m_pol = d;
        8'h34: m_trig = d;
        default: ;
      endcase
    end else if (a < 8'd32) begin
      m_route[a] = d[7:0];
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(negedge clk);
    m_pend = m_pend | edges(m_src, v);
    m_src = v;
    irq_src = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic full_check(input string tag);
    logic [31:0] v;
    rd(8'h40, v); chk({tag, " R9 status"}, v, exp_status());
    rd(8'h24, v); chk({tag, " R5 enables"}, v, m_en);
    #1 chk({tag, " R10 grid"}, {16'h0, irq_out}, {16'h0, exp_grid()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) m_route[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    #1 chk("R1 grid", {16'h0, irq_out}, 32'h0);
    rd(8'h24, v); chk("R1 enables", v, 32'h0);
    rd(8'h30, v); chk("R1 polarity", v, 32'h0);
    rd(8'h34, v); chk("R1 trigger", v, 32'h0);
    rd(8'h40, v); chk("R1 status", v, 32'h0);
    rd(8'h00, v); chk("R1 route", v, 32'h0);

    // R2 routing bytes and word readback
    wr(0, 8'h00, 32'h11); wr(0, 8'h01, 32'h22);
    wr(0, 8'h02, 32'h44); wr(0, 8'h03, 32'h88);
    wr(0, 8'h1F, 32'h5A);
    rd(8'h00, v); chk("R2 route word 0", v, 32'h8844_2211);
    rd(8'h1C, v); chk("R2 route word 7", v, 32'h5A00_0000);

    // R11 wrong-size writes ignored
    wr(0, 8'h28, 32'hFF);
    rd(8'h24, v); chk("R11 byte to enable-set", v, 32'h0);
    wr(0, 8'h34, 32'hFF);
    rd(8'h34, v); chk("R11 byte to trigger", v, 32'h0);
    wr(1, 8'h04, 32'hDEAD_BEEF);
    rd(8'h04, v); chk("R11 word into routing", v, 32'h0);

    // R3 R4 R5 set and clear
    wr(1, 8'h28, 32'h0000_00F0);
    wr(1, 8'h28, 32'h0000_000F);
    rd(8'h24, v); chk("R3 set accumulates", v, 32'h0000_00FF);
    wr(1, 8'h2C, 32'h0000_003C);
    rd(8'h24, v); chk("R4 clear ones", v, 32'h0000_00C3);
    wr(1, 8'h2C, 32'h0);
    wr(1, 8'h28, 32'h0);
    rd(8'h24, v); chk("R4 zeros unchanged", v, 32'h0000_00C3);
    wr(1, 8'h2C, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R4 all-ones clear", v, 32'h0);

    // R6 polarity/trigger readback
    wr(1, 8'h30, 32'hA5A5_0F0F);
    wr(1, 8'h34, 32'h0000_0000);
    rd(8'h30, v); chk("R6 polarity readback", v, 32'hA5A5_0F0F);
    rd(8'h34, v); chk("R6 trigger readback", v, 32'h0);
    wr(1, 8'h30, 32'h0000_0001);

    // R7 active-low level source 2 (pol bit 0) with input low asserts
    wr(1, 8'h28, 32'h0000_0004);
    full_check("R7 active-low");
    #1 chk("R7 line2 core2 out", {31'h0, irq_out[10]}, 32'h1);

    // R7 R10 latency on source 0 (active-high, level)
    wr(1, 8'h28, 32'h0000_0001);
    @(negedge clk);
    bus_addr = 8'h40;
    irq_src = 32'h1;
    @(negedge clk); #1 chk("R7 not after one edge", {31'h0, bus_rdata[0]}, 32'h0);
    @(negedge clk); #1 chk("R7 status after two edges", {31'h0, bus_rdata[0]}, 32'h1);
    chk("R10 output not yet", {31'h0, irq_out[0]}, 32'h0);
    @(negedge clk); #1 chk("R10 output registered", {31'h0, irq_out[0]}, 32'h1);
    m_pend = m_pend | edges(m_src, 32'h1);
    m_src = 32'h1;
    repeat (3) @(negedge clk);

    // R8 rising-edge source 1 routed to line1 core1
    wr(1, 8'h30, 32'h0000_0003);
    wr(1, 8'h34, 32'h0000_0002);
    wr(1, 8'h28, 32'h0000_0002);
    full_check("R8 before edge");
    drive_src(32'h3);
    drive_src(32'h1);
    rd(8'h40, v); chk("R8 pending held", {31'h0, v[1]}, 32'h1);
    #1 chk("R8 out held", {31'h0, irq_out[5]}, 32'h1);
    wr(1, 8'h28, 32'h0000_0100);
    rd(8'h40, v); chk("R8 survives set write", {31'h0, v[1]}, 32'h1);
    wr(1, 8'h2C, 32'h0000_0002);
    wr(1, 8'h28, 32'h0000_0002);
    rd(8'h40, v); chk("R8 cleared by disable", {31'h0, v[1]}, 32'h0);
    // falling edge
    wr(1, 8'h30, 32'h0000_0001);
    drive_src(32'h3);
    rd(8'h40, v); chk("R8 rise ignored when falling", {31'h0, v[1]}, 32'h0);
    drive_src(32'h1);
    rd(8'h40, v); chk("R8 falling edge pends", {31'h0, v[1]}, 32'h1);
    full_check("R8 falling");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: wr(0, 8'($urandom_range(0, 31)), $urandom);
        1: wr(1, 8'h28, $urandom & $urandom);
        2: wr(1, 8'h2C, $urandom & $urandom);
        3: wr(1, 8'h30, $urandom);
        4: wr(1, 8'h34, $urandom);
        default: drive_src($urandom);
      endcase
      if (it % 4 == 0) full_check("R9 R10 random");
    end
    for (int k = 0; k < 8; k++) begin
      rd(8'(4*k), v);
      chk("R2 route random readback", v,
          {m_route[4*k+3], m_route[4*k+2], m_route[4*k+1], m_route[4*k]});
    end
    rd(8'h34, v); chk("R6 trigger random", v, m_trig);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule